// File: doc/BRIEF.md
# Serial Codec Link Command Framer

This block sits on the controller side of a bit-serial codec link. A host issues one register command at a time: a read or a write, a 7-bit register index, 16 bits of write data and a 2-bit target codec number (0 for the primary codec, 1 to 3 for secondary codecs). The block places the command in the next outbound frame. Each frame carries a tag word, an address slot and a data slot, and the block shifts the frame out MSB first on its clock, together with a frame sync.

For a read, the block then watches the inbound serial line for the status frame that follows the command frame. It accepts only a frame whose tag and echoed register index fit the pending read. It then returns the data slot contents with a single-cycle completion pulse. A write completes as soon as its frame has been sent. Tag encoding depends on the target. A command to the primary codec marks the address and data slots valid in the tag word. A command to a secondary codec clears those two tag bits, puts the codec number in the tag's low bits, and lets the read/write bit in the address slot say whether the data slot is meaningful.

Top module: `aclink_cmd_fmt`

## Requirements
- R1: Frames are 256 clocks long and repeat without gaps from reset. `sync` is high for frame positions 0 to 15 and low for positions 16 to 255. Position 0 is the first clock after reset is released.
- R2: For a command to codec 0, tag word bits 15,14,13 are 1,1,0 for a read and 1,1,1 for a write, and tag bits 1:0 are 00.
- R3: For a command to codec 1, 2 or 3, tag bits 15,14,13 are 1,0,0 and tag bits 1:0 carry the codec number.
- R4: The address slot (frame positions 16 to 35, MSB first) carries the read flag in bit 19 (1 = read), the register index in bits 18:12, and zeros in bits 11:0.
- R5: The data slot (positions 36 to 55) carries write data in bits 19:4 with bits 3:0 zero. For a read, all 20 bits are zero.
- R6: A command's tag, address and data all go out in the single frame that follows acceptance, and never in more than one frame. In frames with no command, the whole tag word is zero. Positions 56 to 255 are always zero.
- R7: A write ends with `done` high for exactly one clock at position 0 of the frame after the command frame. `busy` is low in that same clock.
- R8: A read waits for an inbound frame with tag bits 15,14,13 = 111, tag bits 1:0 = 00 and address slot bits 18:12 equal to the pending index. Inbound bits are sampled on the rising clock at the same positions as outbound bits. Frames that do not match are skipped, and `busy` stays high. On a match, `rdata` takes data slot bits 19:4, and `done` pulses for one clock at position 0 of the next frame.
- R9: A request made while `busy` is high is ignored. It produces no extra frame and does not change the pending command.
- R10: During and right after reset, `busy`, `done`, `rdata` and `sdout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Request strobe, taken when not busy |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_idx | input | 7 | Register index |
| req_wdata | input | 16 | Write data |
| req_cid | input | 2 | Target codec number, 0 = primary |
| busy | output | 1 | A command is pending or in flight |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Data returned by the last read |
| sync | output | 1 | Frame sync, high during the tag word |
| sdout | output | 1 | Serial command output, MSB first |
| sdin | input | 1 | Serial status input |

## Verification
The assertions check the things that must hold on every clock. The frame counter must step and wrap. The link must stay quiet after the data slot. `done` must last one clock. The pending command must not change under a request made while busy. A secondary target must always clear its tag valid bits. They also check that no read completes from a status frame that does not match. Only the bench's scenarios can show the rest: the exact bit patterns of whole frames for each target and direction, the frame in which `done` appears, the data returned, and that mismatched status frames really hold off completion until a good frame arrives.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
    localparam int SLOT0_W   = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int IDX_W     = 7;
    localparam int DATA_W    = 16;
    localparam int CID_W     = 2;
    localparam int SYNC_LEN  = SLOT0_W;
    localparam int FRAME_LEN = SLOT0_W + NUM_SLOTS * SLOT_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int CMD_W     = SLOT0_W + 2 * SLOT_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SEND,
        ST_STATUS
    } cmd_state_e;
endpackage

// File: rtl/aclink_frame_ctr.sv
module aclink_frame_ctr #(
    parameter int FRAME_LEN = aclink_pkg::FRAME_LEN,
    parameter int SYNC_LEN  = aclink_pkg::SYNC_LEN,
    parameter int CNT_W     = aclink_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             sync
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign wrap = (cnt_q == LAST);
    assign sync = (cnt_q < CNT_W'(SYNC_LEN));

    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/aclink_tx_slots.sv
module aclink_tx_slots #(
    parameter int SLOT0_W = aclink_pkg::SLOT0_W,
    parameter int SLOT_W  = aclink_pkg::SLOT_W,
    parameter int IDX_W   = aclink_pkg::IDX_W,
    parameter int DATA_W  = aclink_pkg::DATA_W,
    parameter int CID_W   = aclink_pkg::CID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic              load,
    input  logic              cmd_rd,
    input  logic [CID_W-1:0]  cmd_cid,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              sdout
);
    localparam int CMD_W = SLOT0_W + 2 * SLOT_W;

    typedef struct packed {
        logic [CMD_W-1:0] sh;
    } tx_state_t;

    tx_state_t d, q;
    logic               primary;
    logic [SLOT0_W-1:0] w_tag;
    logic [SLOT_W-1:0]  w_addr;
    logic [SLOT_W-1:0]  w_data;

    always_comb begin
        primary = (cmd_cid == '0);
        // secondary targets leave address/data valid tags cleared
        w_tag   = {1'b1, primary, primary & ~cmd_rd,
                   {(SLOT0_W - 3 - CID_W){1'b0}}, cmd_cid};
        w_addr  = {cmd_rd, cmd_idx, {(SLOT_W - 1 - IDX_W){1'b0}}};
        w_data  = cmd_rd ? '0 : {cmd_wdata, {(SLOT_W - DATA_W){1'b0}}};

        d = q;
        if (wrap) begin
            d.sh = load ? {w_tag, w_addr, w_data} : '0;
        end else begin
            d.sh = {q.sh[CMD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdout = q.sh[CMD_W-1];

    assert_sec_tag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wrap && cmd_cid != '0) |=>
        (q.sh[CMD_W-1] && q.sh[CMD_W-2 -: 2] == 2'b00));
    assert_pri_tag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wrap && cmd_cid == '0) |=>
        (q.sh[CMD_W-1 -: 2] == 2'b11 && q.sh[CMD_W-3] == !$past(cmd_rd)));
endmodule

// File: rtl/aclink_rx_status.sv
module aclink_rx_status #(
    parameter int SLOT0_W = aclink_pkg::SLOT0_W,
    parameter int SLOT_W  = aclink_pkg::SLOT_W,
    parameter int IDX_W   = aclink_pkg::IDX_W,
    parameter int DATA_W  = aclink_pkg::DATA_W,
    parameter int CID_W   = aclink_pkg::CID_W,
    parameter int CNT_W   = aclink_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sdin,
    output logic              st_ok,
    output logic [IDX_W-1:0]  st_idx,
    output logic [DATA_W-1:0] st_data
);
    localparam int CMD_W = SLOT0_W + 2 * SLOT_W;

    typedef struct packed {
        logic [CMD_W-1:0] sh;
    } rx_state_t;

    rx_state_t d, q;

    always_comb begin
        d = q;
        if (cnt < CNT_W'(CMD_W)) begin
            d.sh = {q.sh[CMD_W-2:0], sdin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st_ok   = (q.sh[CMD_W-1 -: 3] == 3'b111) &&
                     (q.sh[CMD_W-SLOT0_W +: CID_W] == '0);
    assign st_idx  = q.sh[CMD_W-SLOT0_W-2 -: IDX_W];
    assign st_data = q.sh[SLOT_W-1 -: DATA_W];

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CNT_W'(CMD_W)) |=> $stable(q.sh));
endmodule

// File: rtl/aclink_cmd_fmt.sv
module aclink_cmd_fmt #(
    parameter int IDX_W  = aclink_pkg::IDX_W,
    parameter int DATA_W = aclink_pkg::DATA_W,
    parameter int CID_W  = aclink_pkg::CID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rd,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CID_W-1:0]  req_cid,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              sync,
    output logic              sdout,
    input  logic              sdin
);
    import aclink_pkg::*;

    typedef struct packed {
        cmd_state_e        st;
        logic              rd;
        logic [CID_W-1:0]  cid;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;

    ctl_state_t d, q;

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              load;
    logic              st_ok;
    logic [IDX_W-1:0]  st_idx;
    logic [DATA_W-1:0] st_data;
    logic              st_match;

    aclink_frame_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .wrap  (wrap),
        .sync  (sync)
    );

    aclink_tx_slots #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .CID_W  (CID_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .load      (load),
        .cmd_rd    (q.rd),
        .cmd_cid   (q.cid),
        .cmd_idx   (q.idx),
        .cmd_wdata (q.wdata),
        .sdout     (sdout)
    );

    aclink_rx_status #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .CID_W  (CID_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .sdin    (sdin),
        .st_ok   (st_ok),
        .st_idx  (st_idx),
        .st_data (st_data)
    );

    assign load     = (q.st == ST_ARMED);
    assign st_match = st_ok && (st_idx == q.idx);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req) begin
                    d.rd    = req_rd;
                    d.cid   = req_cid;
                    d.idx   = req_idx;
                    d.wdata = req_wdata;
                    d.st    = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (wrap) d.st = ST_SEND;
            end
            ST_SEND: begin
                if (wrap) begin
                    if (q.rd) begin
                        d.st = ST_STATUS;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            ST_STATUS: begin
                if (wrap && st_match) begin
                    d.rdata = st_data;
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy  = (q.st != ST_IDLE);
    assign done  = q.done;
    assign rdata = q.rdata;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_at_frame_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == '0));
    assert_quiet_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= CNT_W'(CMD_W)) |-> !sdout);
    assert_status_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STATUS && wrap && !st_match) |=> (busy && !done));
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(q.idx) && $stable(q.rd) && $stable(q.cid)));
endmodule

// File: tb/aclink_cmd_fmt_tb.sv
module aclink_cmd_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_rd = 1'b0;
    logic [6:0]  req_idx = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_cid = '0;
    logic        busy, done, sync, sdout;
    logic [15:0] rdata;
    logic        sdin = 1'b0;

    int total = 0;
    int bad = 0;

    aclink_cmd_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd),
        .req_idx(req_idx), .req_wdata(req_wdata), .req_cid(req_cid),
        .busy(busy), .done(done), .rdata(rdata), .sync(sync),
        .sdout(sdout), .sdin(sdin)
    );

    always #10 clk = ~clk;

    // link monitor and status responder
    logic [55:0] rsp = '0;
    logic [55:0] cur = '0;
    logic [15:0] cmd_s0 = '0;
    logic [19:0] cmd_s1 = '0, cmd_s2 = '0;
    int pos = 0;
    bit aligned = 0;
    int cmd_cnt = 0, done_cnt = 0, done_pos = -1;
    int sync_bad = 0, tail_bad = 0, idle_bad = 0, frames = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!aligned) begin
                aligned = 1;
                pos = 0;
            end else begin
                pos = (pos + 1) % 256;
            end
            if (sync != (pos < 16)) sync_bad++;
            if (pos < 56) cur = {cur[54:0], sdout};
            else if (sdout) tail_bad++;
            if (pos == 55) begin
                frames++;
                if (cur[55]) begin
                    cmd_cnt++;
                    cmd_s0 = cur[55:40];
                    cmd_s1 = cur[39:20];
                    cmd_s2 = cur[19:0];
                end else if (cur[55:40] != 16'h0) begin
                    idle_bad++;
                end
            end
            if (done) begin
                done_cnt++;
                done_pos = pos;
            end
            sdin = (pos < 56) ? rsp[55 - pos] : 1'b0;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_tag(input logic rd, input logic [1:0] cid);
        return {1'b1, cid == 2'b00, (cid == 2'b00) && !rd, 11'b0, cid};
    endfunction

    function automatic logic [55:0] mk_rsp(input logic [2:0] tag, input logic [1:0] id,
                                           input logic [6:0] idx, input logic [15:0] dat);
        return {tag, 11'b0, id, 1'b0, idx, 12'b0, dat, 4'b0};
    endfunction

    task automatic issue(input logic rd, input logic [1:0] cid, input logic [6:0] idx,
                         input logic [15:0] wd);
        @(negedge clk); #1;
        req = 1'b1; req_rd = rd; req_cid = cid; req_idx = idx; req_wdata = wd;
        @(negedge clk); #1;
        req = 1'b0;
    endtask

    task automatic wait_done(input int limit, output bit seen);
        int start;
        start = done_cnt;
        seen = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk); #1;
            if (done_cnt != start) begin
                seen = 1;
                break;
            end
        end
    endtask

    // {rd, cid, idx, wdata, returned data}
    localparam logic [41:0] VEC [6] = '{
        {1'b1, 2'd0, 7'h26, 16'h0000, 16'hBEEF},
        {1'b0, 2'd0, 7'h02, 16'h8A5C, 16'h0000},
        {1'b1, 2'd1, 7'h7C, 16'h0000, 16'h1234},
        {1'b0, 2'd2, 7'h18, 16'hFFFF, 16'h0000},
        {1'b1, 2'd3, 7'h00, 16'h0000, 16'h0001},
        {1'b0, 2'd0, 7'h7F, 16'h0000, 16'h0000}
    };

    initial begin
        bit seen;
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 busy in reset", 32'(busy), 0);
        check("R10 done in reset", 32'(done), 0);
        check("R10 sdout in reset", 32'(sdout), 0);
        check("R10 rdata in reset", 32'(rdata), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check("R10 busy after reset", 32'(busy), 0);
        check("R1 sync at position 0", 32'(sync), 1);
        repeat (600) @(negedge clk);

        foreach (VEC[k]) begin
            logic        rd;
            logic [1:0]  cid;
            logic [6:0]  idx;
            logic [15:0] wd, rv;
            int c0;
            {rd, cid, idx, wd, rv} = VEC[k];
            rsp = mk_rsp(3'b111, 2'b00, idx, rv);
            c0 = cmd_cnt;
            issue(rd, cid, idx, wd);
            wait_done(1200, seen);
            check(rd ? "R8 read done seen" : "R7 write done seen", 32'(seen), 1);
            check(rd ? "R8 done at frame start" : "R7 done at frame start", 32'(done_pos), 0);
            check("R7 busy low with done", 32'(busy), 0);
            check("R6 one command frame", 32'(cmd_cnt - c0), 1);
            check(cid == 0 ? "R2 tag word" : "R3 tag word", 32'(cmd_s0), 32'(exp_tag(rd, cid)));
            check("R4 address slot", 32'(cmd_s1), 32'({rd, idx, 12'b0}));
            check("R5 data slot", 32'(cmd_s2), rd ? 32'd0 : 32'({wd, 4'b0}));
            if (rd) check("R8 read data", 32'(rdata), 32'(rv));
            @(negedge clk); #1;
            check("R7 done one clock", 32'(done), 0);
        end

        // R9: request during busy is ignored
        begin
            int c0;
            c0 = cmd_cnt;
            issue(1'b0, 2'd0, 7'h11, 16'h1111);
            repeat (2) @(negedge clk);
            issue(1'b1, 2'd2, 7'h22, 16'h2222);
            wait_done(1200, seen);
            check("R9 first command done", 32'(seen), 1);
            check("R9 pending address kept", 32'(cmd_s1), 32'({1'b0, 7'h11, 12'b0}));
            repeat (700) @(negedge clk);
            check("R9 no extra frame", 32'(cmd_cnt - c0), 1);
            check("R9 not busy afterwards", 32'(busy), 0);
        end

        // R8: mismatching status frames are skipped
        begin
            int d0;
            rsp = mk_rsp(3'b111, 2'b00, 7'h34, 16'hDEAD);
            d0 = done_cnt;
            issue(1'b1, 2'd0, 7'h33, 16'h0);
            repeat (900) @(negedge clk);
            check("R8 wrong index keeps busy", 32'(busy), 1);
            rsp = mk_rsp(3'b110, 2'b00, 7'h33, 16'hDEAD);
            repeat (600) @(negedge clk);
            check("R8 bad tag keeps busy", 32'(busy), 1);
            rsp = mk_rsp(3'b111, 2'b01, 7'h33, 16'hDEAD);
            repeat (600) @(negedge clk);
            check("R8 nonzero status id keeps busy", 32'(busy), 1);
            check("R8 no early done", 32'(done_cnt - d0), 0);
            rsp = mk_rsp(3'b111, 2'b00, 7'h33, 16'h5A5A);
            wait_done(1200, seen);
            check("R8 matching status completes", 32'(seen), 1);
            check("R8 data after retry", 32'(rdata), 32'h5A5A);
        end

        repeat (300) @(negedge clk);
        check("R1 sync pattern", 32'(sync_bad), 0);
        check("R1 frames observed", 32'(frames > 20), 1);
        check("R6 quiet tail", 32'(tail_bad), 0);
        check("R6 idle tag zero", 32'(idle_bad), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule